// File: doc/BRIEF.md
# Staged Pipeline Control Decoder

This block turns the opcode of the instruction in the decode stage into the nine main control lines of a five-stage processor. It then hands those lines down the pipeline through three stage registers. The lines are split by the stage that uses them. The execute group steers the ALU operand and the destination choice. The memory group drives branch, load and store. The write-back group enables the register write and picks its source. Each group leaves the pipeline once its stage has used it, so each stage register is narrower than the one before it.

The destination register number is chosen in decode from one of two instruction fields and travels with the write-back group. It therefore reaches write-back in the same cycle as the write enable it belongs to. When a slot carries no instruction (a bubble), that slot holds all-zero control as it moves down the pipe. The stage registers load on every clock, with no enable and no sequencer.

Instruction encoding: the opcode is bits 31..26, the second source field is bits 20..16 and the third register field is bits 15..11.

Top module: `ctl_pipe_top`

## Requirements
- R1: Opcode 0 (register format) decodes to execute group dst_sel=1, alu_src=0, alu_op=2'b10, memory group all 0, and write-back group reg_wr=1, wb_sel=0.
- R2: Opcode 35 (load) decodes to dst_sel=0, alu_src=1, alu_op=2'b00, mem_rd=1, branch=0, mem_wr=0, reg_wr=1, wb_sel=1.
- R3: Opcode 43 (store) decodes to alu_src=1, alu_op=2'b00, mem_wr=1, and all other lines 0. This includes reg_wr, and also dst_sel and wb_sel, whose values do not matter for a store.
- R4: Opcode 4 (branch-if-equal) decodes to alu_op=2'b01, branch=1, and all other lines 0.
- R5: Any other opcode decodes to all nine control lines 0.
- R6: The execute group of an instruction presented at the decode input appears after the next rising edge. Its memory group appears after the second rising edge, and its write-back group after the third. Every stage register loads on every edge.
- R7: The destination number is instruction bits 15..11 when the decoded dst_sel is 1 and bits 20..16 otherwise. It appears on the write-back destination output in the same cycle as that instruction's write-back group.
- R8: An input slot with the valid flag low carries all-zero control and a zero destination through every stage, whatever its opcode.
- R9: A synchronous active-high reset clears all three stage registers, so every output is 0 after an edge with reset high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word in the decode stage |
| instr_valid_i | input | 1 | High when the decode slot holds a real instruction |
| ex_dst_sel_o | output | 1 | Execute: destination field select |
| ex_alu_src_o | output | 1 | Execute: second ALU operand is the immediate |
| ex_alu_op_o | output | 2 | Execute: ALU operation class |
| mem_branch_o | output | 1 | Memory: conditional branch |
| mem_rd_o | output | 1 | Memory: data read |
| mem_wr_o | output | 1 | Memory: data write |
| wb_reg_wr_o | output | 1 | Write-back: register file write enable |
| wb_sel_o | output | 1 | Write-back: write data from memory (1) or ALU (0) |
| wb_dest_o | output | 5 | Write-back: destination register number |

## Verification
An instruction driven on the decode input is due on the execute outputs one rising edge later. Its memory outputs are due two edges later, and its write-back group and destination three edges later. The bench keeps a three-deep record of what was driven in each slot and shifts it on each rising edge, so each output group is compared with the slot of matching age. Inputs change and outputs are sampled on the falling edge, halfway between the edge that updates the design and the one that consumes the inputs. The resets, bubbles, unknown opcodes and back-to-back instructions are therefore all checked in the exact cycle their results are due.

// File: rtl/ctl_pipe_pkg.sv
package ctl_pipe_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;
    localparam logic [OPC_W-1:0] OPC_BREQ  = 6'd4;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_SUB  = 2'b01,
        ALU_FUNC = 2'b10
    } alu_cls_e;

    typedef struct packed {
        logic     dst_sel;
        logic     alu_src;
        alu_cls_e alu_op;
    } ex_ctl_t;

    typedef struct packed {
        logic branch;
        logic rd;
        logic wr;
    } mem_ctl_t;

    typedef struct packed {
        logic reg_wr;
        logic sel;
    } wb_ctl_t;

    typedef struct packed {
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } main_ctl_t;

    localparam int EX_BITS  = $bits(ex_ctl_t);
    localparam int MEM_BITS = $bits(mem_ctl_t);
    localparam int WB_BITS  = $bits(wb_ctl_t);

    function automatic main_ctl_t decode_opc(input logic [OPC_W-1:0] opc);
        main_ctl_t c;
        c = '0;
        c.ex.alu_op = ALU_ADD;
        unique case (opc)
            OPC_REG: begin
                c.ex.dst_sel = 1'b1;
                c.ex.alu_op  = ALU_FUNC;
                c.wb.reg_wr  = 1'b1;
            end
            OPC_LOAD: begin
                c.ex.alu_src = 1'b1;
                c.mem.rd     = 1'b1;
                c.wb.reg_wr  = 1'b1;
                c.wb.sel     = 1'b1;
            end
            OPC_STORE: begin
                c.ex.alu_src = 1'b1;
                c.mem.wr     = 1'b1;
            end
            OPC_BREQ: begin
                c.ex.alu_op  = ALU_SUB;
                c.mem.branch = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_pipe_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int REG_W   = 5
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               valid,
    output main_ctl_t          ctl,
    output logic [REG_W-1:0]   dest
);
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RT_LSB  = OPC_LSB - 2 * REG_W;
    localparam int RD_LSB  = RT_LSB - REG_W;

    logic [OPC_W-1:0] opc;
    main_ctl_t        raw;
    logic             unused_fields;

    assign opc = instr[OPC_LSB +: OPC_W];
    assign unused_fields = ^{instr[RT_LSB+REG_W +: REG_W], instr[RD_LSB-1:0]};

    always_comb begin
        raw = decode_opc(opc);
        if (valid) begin
            ctl  = raw;
            dest = raw.ex.dst_sel ? instr[RD_LSB +: REG_W] : instr[RT_LSB +: REG_W];
        end else begin
            ctl  = '0;
            dest = '0;
        end
    end
endmodule

// File: rtl/ctl_stage_reg.sv
module ctl_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/ctl_pipe_top.sv
module ctl_pipe_top
    import ctl_pipe_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int REG_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               instr_valid_i,
    output logic               ex_dst_sel_o,
    output logic               ex_alu_src_o,
    output logic [1:0]         ex_alu_op_o,
    output logic               mem_branch_o,
    output logic               mem_rd_o,
    output logic               mem_wr_o,
    output logic               wb_reg_wr_o,
    output logic               wb_sel_o,
    output logic [REG_W-1:0]   wb_dest_o
);
    localparam int WB_W  = WB_BITS + REG_W;
    localparam int MEM_W = MEM_BITS + WB_W;
    localparam int EX_W  = EX_BITS + MEM_W;

    main_ctl_t        dec_ctl;
    logic [REG_W-1:0] dec_dest;

    logic [EX_W-1:0]  idex_d,  idex_q;
    logic [MEM_W-1:0] exmem_d, exmem_q;
    logic [WB_W-1:0]  memwb_d, memwb_q;

    ex_ctl_t  ex_s;
    mem_ctl_t mem_s;
    wb_ctl_t  wb_s;

    ctl_decode #(.INSTR_W(INSTR_W), .REG_W(REG_W)) u_dec (
        .instr (instr_i),
        .valid (instr_valid_i),
        .ctl   (dec_ctl),
        .dest  (dec_dest)
    );

    assign idex_d  = {dec_ctl.ex, dec_ctl.mem, dec_ctl.wb, dec_dest};
    assign exmem_d = idex_q[MEM_W-1:0];
    assign memwb_d = exmem_q[WB_W-1:0];

    ctl_stage_reg #(.W(EX_W)) u_idex (
        .clk (clk), .rst (rst), .d (idex_d), .q (idex_q)
    );
    ctl_stage_reg #(.W(MEM_W)) u_exmem (
        .clk (clk), .rst (rst), .d (exmem_d), .q (exmem_q)
    );
    ctl_stage_reg #(.W(WB_W)) u_memwb (
        .clk (clk), .rst (rst), .d (memwb_d), .q (memwb_q)
    );

    assign ex_s  = ex_ctl_t'(idex_q[EX_W-1 -: EX_BITS]);
    assign mem_s = mem_ctl_t'(exmem_q[MEM_W-1 -: MEM_BITS]);
    assign wb_s  = wb_ctl_t'(memwb_q[WB_W-1 -: WB_BITS]);

    assign ex_dst_sel_o = ex_s.dst_sel;
    assign ex_alu_src_o = ex_s.alu_src;
    assign ex_alu_op_o  = ex_s.alu_op;
    assign mem_branch_o = mem_s.branch;
    assign mem_rd_o     = mem_s.rd;
    assign mem_wr_o     = mem_s.wr;
    assign wb_reg_wr_o  = wb_s.reg_wr;
    assign wb_sel_o     = wb_s.sel;
    assign wb_dest_o    = memwb_q[REG_W-1:0];
endmodule

// File: rtl/ctl_pipe_chk.sv
module ctl_pipe_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             ex_dst_sel_o,
    input logic             ex_alu_src_o,
    input logic [1:0]       ex_alu_op_o,
    input logic             mem_branch_o,
    input logic             mem_rd_o,
    input logic             mem_wr_o,
    input logic             wb_reg_wr_o,
    input logic             wb_sel_o,
    input logic [REG_W-1:0] wb_dest_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!ex_dst_sel_o && !ex_alu_src_o && ex_alu_op_o == 2'b00 &&
                 !mem_branch_o && !mem_rd_o && !mem_wr_o &&
                 !wb_reg_wr_o && !wb_sel_o && wb_dest_o == '0)); // R9

    AST_REG_FMT_EX: assert property (@(posedge clk) disable iff (rst)
        ex_dst_sel_o |-> (!ex_alu_src_o && ex_alu_op_o == 2'b10)); // R1

    AST_LOAD_TO_WB: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |=> (wb_reg_wr_o && wb_sel_o)); // R2

    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        mem_wr_o |=> (!wb_reg_wr_o && !wb_sel_o)); // R3

    AST_BRANCH_STAGED: assert property (@(posedge clk) disable iff (rst)
        (ex_alu_op_o == 2'b01) |=> mem_branch_o); // R4

    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_branch_o, mem_rd_o, mem_wr_o})); // R5

    AST_MEM_NEEDS_IMM: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o || mem_wr_o) |-> $past(ex_alu_src_o)); // R6

    AST_WBSEL_NEEDS_WR: assert property (@(posedge clk) disable iff (rst)
        wb_sel_o |-> wb_reg_wr_o); // R8
endmodule

bind ctl_pipe_top ctl_pipe_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/sim_ctl_pipe_top.sv
`timescale 1ns/1ps
module sim_ctl_pipe_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr_i = '0;
    logic        instr_valid_i = 1'b0;
    logic        ex_dst_sel_o, ex_alu_src_o, mem_branch_o, mem_rd_o, mem_wr_o;
    logic        wb_reg_wr_o, wb_sel_o;
    logic [1:0]  ex_alu_op_o;
    logic [4:0]  wb_dest_o;

    int n_run = 0;
    int n_fail = 0;
    bit go = 1'b0;
    bit done = 1'b0;

    // model slots: age 0 = in execute, 1 = in memory, 2 = in write-back
    logic [31:0] m_ins [3];
    logic        m_val [3];
    logic        m_rst [3];

    always #4 clk = ~clk;

    ctl_pipe_top u0 (
        .clk (clk), .rst (rst), .instr_i (instr_i), .instr_valid_i (instr_valid_i),
        .ex_dst_sel_o (ex_dst_sel_o), .ex_alu_src_o (ex_alu_src_o), .ex_alu_op_o (ex_alu_op_o),
        .mem_branch_o (mem_branch_o), .mem_rd_o (mem_rd_o), .mem_wr_o (mem_wr_o),
        .wb_reg_wr_o (wb_reg_wr_o), .wb_sel_o (wb_sel_o), .wb_dest_o (wb_dest_o)
    );

    function automatic logic [3:0] exp_ex(logic [31:0] ins, logic v);
        if (!v) return 4'b0;
        case (ins[31:26])
            6'd0:  return 4'b1010;
            6'd35: return 4'b0100;
            6'd43: return 4'b0100;
            6'd4:  return 4'b0001;
            default: return 4'b0;
        endcase
    endfunction

    function automatic logic [2:0] exp_mem(logic [31:0] ins, logic v);
        if (!v) return 3'b0;
        case (ins[31:26])
            6'd4:  return 3'b100;
            6'd35: return 3'b010;
            6'd43: return 3'b001;
            default: return 3'b0;
        endcase
    endfunction

    function automatic logic [1:0] exp_wb(logic [31:0] ins, logic v);
        if (!v) return 2'b0;
        case (ins[31:26])
            6'd0:  return 2'b10;
            6'd35: return 2'b11;
            default: return 2'b0;
        endcase
    endfunction

    function automatic logic [4:0] exp_dest(logic [31:0] ins, logic v);
        if (!v) return 5'd0;
        return (ins[31:26] == 6'd0) ? ins[15:11] : ins[20:16];
    endfunction

    function automatic string tag_of(logic [31:0] ins, logic v, logic r);
        if (r)  return "R9";
        if (!v) return "R8";
        case (ins[31:26])
            6'd0:  return "R1";
            6'd35: return "R2";
            6'd43: return "R3";
            6'd4:  return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 3; k++) begin
                m_val[k] <= 1'b0; m_rst[k] <= 1'b1; m_ins[k] <= '0;
            end
        end else begin
            m_ins[0] <= instr_i; m_val[0] <= instr_valid_i; m_rst[0] <= 1'b0;
            for (int k = 1; k < 3; k++) begin
                m_ins[k] <= m_ins[k-1]; m_val[k] <= m_val[k-1]; m_rst[k] <= m_rst[k-1];
            end
        end
        go <= 1'b1;
    end

    // R6: each group compared against the slot of matching age
    always @(negedge clk) begin
        if (go && !done) begin
            check({tag_of(m_ins[0], m_val[0], m_rst[0]), " R6"}, "ex group",
                  int'({ex_dst_sel_o, ex_alu_src_o, ex_alu_op_o}), int'(exp_ex(m_ins[0], m_val[0])));
            check({tag_of(m_ins[1], m_val[1], m_rst[1]), " R6"}, "mem group",
                  int'({mem_branch_o, mem_rd_o, mem_wr_o}), int'(exp_mem(m_ins[1], m_val[1])));
            check({tag_of(m_ins[2], m_val[2], m_rst[2]), " R6"}, "wb group",
                  int'({wb_reg_wr_o, wb_sel_o}), int'(exp_wb(m_ins[2], m_val[2])));
            check({tag_of(m_ins[2], m_val[2], m_rst[2]), " R7"}, "wb dest",
                  int'(wb_dest_o), int'(exp_dest(m_ins[2], m_val[2])));
        end
    end

    task automatic put(logic [5:0] opc, logic v);
        @(negedge clk);
        instr_i = {opc, 5'($urandom), 5'($urandom), 5'($urandom), 11'($urandom)};
        instr_valid_i = v;
    endtask

    initial begin : stim
        logic [5:0] pool [7];
        pool = '{6'd0, 6'd35, 6'd43, 6'd4, 6'd8, 6'd63, 6'd2};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        put(6'd0, 1'b1);  put(6'd35, 1'b1); put(6'd43, 1'b1); put(6'd4, 1'b1);
        put(6'd8, 1'b1);  put(6'd63, 1'b1); put(6'd35, 1'b0); put(6'd0, 1'b0);
        put(6'd35, 1'b1); put(6'd35, 1'b1); put(6'd0, 1'b1);  put(6'd4, 1'b1);
        for (int i = 0; i < 300; i++)
            put(pool[$urandom_range(0, 6)], ($urandom_range(0, 9) < 8));
        put(6'd35, 1'b1); put(6'd0, 1'b1);
        @(negedge clk); rst = 1'b1; instr_i = {6'd35, 26'h3ffffff}; instr_valid_i = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        put(6'd43, 1'b1); put(6'd0, 1'b1);
        for (int i = 0; i < 4; i++) put(6'd0, 1'b0);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule